// File: doc/BRIEF.md
# Tag-Matching Reservation Station

This block is a small issue queue that sits in front of a single execution unit. Each entry holds an operation code and two operands. An operand holds either its final value, or the tag of the result that will produce it. New work arrives on a dispatch port that states, for each operand, whether the value is already known. A result broadcast bus carries a tag and a value. Every waiting operand whose tag equals the broadcast tag takes the value and becomes ready.

Each cycle the block forwards at most one entry to the execution unit, and only an entry whose two operands are both ready. The operation code and both stored values leave the queue directly. The queue is kept in age order: the oldest entry is in slot 0. When an entry leaves, every younger entry moves down one slot. Because the oldest ready entry always wins, an old entry cannot be passed over for ever by younger ones.

Renaming, result ordering and the execution unit are outside this block. The unit is assumed to accept one operation in every cycle.

Top module: `tag_match_station`

## Requirements
- R1: After reset, and whenever reset is asserted, the queue is empty: `issueValid` is 0, `full` is 0, and nothing queued before the reset is issued afterwards.
- R2: An entry dispatched with both operands marked ready drives `issueValid`=1 in the next cycle. In that cycle `issueOp`, `issueA` and `issueB` equal the dispatched op code and operand values.
- R3: A waiting operand is filled by a broadcast only when its stored tag equals `bcTag`. A broadcast with a different tag leaves the entry waiting. After a matching broadcast at a clock edge, the entry may issue in the cycle after that edge, carrying `bcVal` as that operand.
- R4: If a broadcast arrives in the same cycle as the dispatch of an operand waiting on that tag, the value is taken into the new entry, and the entry is ready from its first cycle in the queue.
- R5: When several entries are ready, the one nearest slot 0, which is the oldest, is issued.
- R6: When an entry leaves, the remaining entries keep their age order. Among entries that become ready together, the oldest issues first.
- R7: `full` is 1 when all DEPTH slots are occupied and no entry issues in that cycle. A dispatch presented while `full` is 1 is dropped and never issues.
- R8: When all slots are occupied and an entry issues in the same cycle, `full` is 0 and a dispatch in that cycle is accepted.
- R9: A broadcast does not change an operand that is already ready, even when that operand's tag field equals `bcTag`.
- R10: At most one entry issues per cycle. Entries that are ready at the same time leave in consecutive cycles, oldest first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Dispatch request |
| dispOp | input | OP_W | Operation code of the dispatched entry |
| dispARdy | input | 1 | Operand A value is known |
| dispATag | input | TAG_W | Tag that operand A waits on |
| dispAVal | input | DATA_W | Operand A value when ready |
| dispBRdy | input | 1 | Operand B value is known |
| dispBTag | input | TAG_W | Tag that operand B waits on |
| dispBVal | input | DATA_W | Operand B value when ready |
| bcValid | input | 1 | Result broadcast valid |
| bcTag | input | TAG_W | Tag of the broadcast result |
| bcVal | input | DATA_W | Value of the broadcast result |
| full | output | 1 | No slot is available this cycle; a dispatch is dropped |
| issueValid | output | 1 | An entry is issued this cycle |
| issueOp | output | OP_W | Operation code of the issued entry |
| issueA | output | DATA_W | Operand A value of the issued entry |
| issueB | output | DATA_W | Operand B value of the issued entry |

## Verification
The bench builds the station with DEPTH=4, TAG_W=4, DATA_W=8 and OP_W=3. A depth of four lets a few dispatches fill the queue, so the full-and-drop case and the issue-frees-a-slot case are both reached in one short sequence. The same sequence also covers the cases where a younger entry is ready before an older one and where several entries become ready from a single broadcast. Four tag bits allow a broadcast that matches nothing, and one tag shared by both operands of one entry and by operands spread over several entries.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // Strobes sent by the control to the datapath in each cycle
  typedef struct packed {
    logic issueEn;  // the selected slot leaves; younger slots move down
    logic dispEn;   // write the dispatched entry into the append slot
  } rsStrobe_t;
endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dispValid,
  input  logic [DEPTH-1:0] rdyVec,
  output rsStrobe_t        strobe,
  output logic [IDX_W-1:0] issueIdx,
  output logic [IDX_W-1:0] dispIdx,
  output logic [CNT_W-1:0] count,
  output logic             issueValid,
  output logic             full
);

  logic [DEPTH-1:0] validVec;
  logic [DEPTH-1:0] eligible;

  // Slots below the occupancy count hold entries; they are packed at the bottom
  for (genvar i = 0; i < DEPTH; i++) begin : g_valid
    assign validVec[i] = CNT_W'(i) < count;
  end

  assign eligible = validVec & rdyVec;

  // Oldest-first pick: the lowest eligible slot wins
  always_comb begin
    issueIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (eligible[i]) issueIdx = IDX_W'(i);
    end
  end

  assign issueValid     = |eligible;
  assign full           = (count == CNT_W'(DEPTH)) && !issueValid;
  assign strobe.issueEn = issueValid;
  assign strobe.dispEn  = dispValid && !full;
  assign dispIdx        = IDX_W'(count - CNT_W'(issueValid));

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else       count <= count + CNT_W'(strobe.dispEn) - CNT_W'(strobe.issueEn);
  end

endmodule

// File: rtl/rs_datapath.sv
module rs_datapath
  import rs_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int OP_W   = 4,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rsStrobe_t         strobe,
  input  logic [IDX_W-1:0]  issueIdx,
  input  logic [IDX_W-1:0]  dispIdx,
  input  logic [OP_W-1:0]   dispOp,
  input  logic              dispARdy,
  input  logic [TAG_W-1:0]  dispATag,
  input  logic [DATA_W-1:0] dispAVal,
  input  logic              dispBRdy,
  input  logic [TAG_W-1:0]  dispBTag,
  input  logic [DATA_W-1:0] dispBVal,
  input  logic              bcValid,
  input  logic [TAG_W-1:0]  bcTag,
  input  logic [DATA_W-1:0] bcVal,
  output logic [DEPTH-1:0]  rdyVec,
  output logic [OP_W-1:0]   issueOp,
  output logic [DATA_W-1:0] issueA,
  output logic [DATA_W-1:0] issueB
);

  // Slot storage
  logic [OP_W-1:0]   opQ   [DEPTH];
  logic [DEPTH-1:0]  aRdyQ, bRdyQ;
  logic [TAG_W-1:0]  aTagQ [DEPTH];
  logic [TAG_W-1:0]  bTagQ [DEPTH];
  logic [DATA_W-1:0] aValQ [DEPTH];
  logic [DATA_W-1:0] bValQ [DEPTH];

  // Slot contents after this cycle's broadcast capture
  logic [DEPTH-1:0]  aRdyC, bRdyC;
  logic [DATA_W-1:0] aValC [DEPTH];
  logic [DATA_W-1:0] bValC [DEPTH];

  // Next-state contents after collapse and append
  logic [OP_W-1:0]   opN   [DEPTH];
  logic [DEPTH-1:0]  aRdyN, bRdyN;
  logic [TAG_W-1:0]  aTagN [DEPTH];
  logic [TAG_W-1:0]  bTagN [DEPTH];
  logic [DATA_W-1:0] aValN [DEPTH];
  logic [DATA_W-1:0] bValN [DEPTH];

  // Dispatched entry after same-cycle capture
  logic              newARdy, newBRdy;
  logic [DATA_W-1:0] newAVal, newBVal;
  logic              newAHit, newBHit;

  // Associative capture into every waiting operand
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic aHit;
      logic bHit;
      aHit     = bcValid && !aRdyQ[i] && (aTagQ[i] == bcTag);
      bHit     = bcValid && !bRdyQ[i] && (bTagQ[i] == bcTag);
      aRdyC[i] = aRdyQ[i] | aHit;
      bRdyC[i] = bRdyQ[i] | bHit;
      aValC[i] = aHit ? bcVal : aValQ[i];
      bValC[i] = bHit ? bcVal : bValQ[i];
    end
  end

  // The same capture applied to the operands being dispatched
  assign newAHit = bcValid && !dispARdy && (dispATag == bcTag);
  assign newBHit = bcValid && !dispBRdy && (dispBTag == bcTag);
  assign newARdy = dispARdy | newAHit;
  assign newBRdy = dispBRdy | newBHit;
  assign newAVal = newAHit ? bcVal : dispAVal;
  assign newBVal = newBHit ? bcVal : dispBVal;

  // Collapse above the issued slot, then append at the first free slot
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic [IDX_W-1:0] src;
      src = IDX_W'(i);
      if (strobe.issueEn && (IDX_W'(i) >= issueIdx) && (i < DEPTH - 1))
        src = IDX_W'(i + 1);
      opN[i]   = opQ[src];
      aRdyN[i] = aRdyC[src];
      bRdyN[i] = bRdyC[src];
      aTagN[i] = aTagQ[src];
      bTagN[i] = bTagQ[src];
      aValN[i] = aValC[src];
      bValN[i] = bValC[src];
      if (strobe.dispEn && (dispIdx == IDX_W'(i))) begin
        opN[i]   = dispOp;
        aRdyN[i] = newARdy;
        bRdyN[i] = newBRdy;
        aTagN[i] = dispATag;
        bTagN[i] = dispBTag;
        aValN[i] = newAVal;
        bValN[i] = newBVal;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aRdyQ <= '0;
      bRdyQ <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        opQ[i]   <= '0;
        aTagQ[i] <= '0;
        bTagQ[i] <= '0;
        aValQ[i] <= '0;
        bValQ[i] <= '0;
      end
    end else begin
      aRdyQ <= aRdyN;
      bRdyQ <= bRdyN;
      for (int i = 0; i < DEPTH; i++) begin
        opQ[i]   <= opN[i];
        aTagQ[i] <= aTagN[i];
        bTagQ[i] <= bTagN[i];
        aValQ[i] <= aValN[i];
        bValQ[i] <= bValN[i];
      end
    end
  end

  assign rdyVec  = aRdyQ & bRdyQ;
  assign issueOp = opQ[issueIdx];
  assign issueA  = aValQ[issueIdx];
  assign issueB  = bValQ[issueIdx];

endmodule

// File: rtl/tag_match_station.sv
module tag_match_station
  import rs_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int OP_W   = 4,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dispValid,
  input  logic [OP_W-1:0]   dispOp,
  input  logic              dispARdy,
  input  logic [TAG_W-1:0]  dispATag,
  input  logic [DATA_W-1:0] dispAVal,
  input  logic              dispBRdy,
  input  logic [TAG_W-1:0]  dispBTag,
  input  logic [DATA_W-1:0] dispBVal,
  input  logic              bcValid,
  input  logic [TAG_W-1:0]  bcTag,
  input  logic [DATA_W-1:0] bcVal,
  output logic              full,
  output logic              issueValid,
  output logic [OP_W-1:0]   issueOp,
  output logic [DATA_W-1:0] issueA,
  output logic [DATA_W-1:0] issueB
);

  rsStrobe_t        strobe;
  logic [DEPTH-1:0] rdyVec;
  logic [IDX_W-1:0] issueIdx;
  logic [IDX_W-1:0] dispIdx;
  logic [CNT_W-1:0] count;

  rs_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .dispValid  (dispValid),
    .rdyVec     (rdyVec),
    .strobe     (strobe),
    .issueIdx   (issueIdx),
    .dispIdx    (dispIdx),
    .count      (count),
    .issueValid (issueValid),
    .full       (full)
  );

  rs_datapath #(
    .DEPTH(DEPTH), .OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .issueIdx (issueIdx),
    .dispIdx  (dispIdx),
    .dispOp   (dispOp),
    .dispARdy (dispARdy),
    .dispATag (dispATag),
    .dispAVal (dispAVal),
    .dispBRdy (dispBRdy),
    .dispBTag (dispBTag),
    .dispBVal (dispBVal),
    .bcValid  (bcValid),
    .bcTag    (bcTag),
    .bcVal    (bcVal),
    .rdyVec   (rdyVec),
    .issueOp  (issueOp),
    .issueA   (issueA),
    .issueB   (issueB)
  );

endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             dispValid,
  input logic             full,
  input logic             issueValid,
  input logic             dispEn,
  input logic             issueEn,
  input logic [CNT_W-1:0] count,
  input logic [DEPTH-1:0] rdyVec,
  input logic [IDX_W-1:0] issueIdx
);

  // R7
  no_accept_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !dispEn);

  // R7
  full_means_occupied_chk: assert property (@(posedge clk) disable iff (!rstN)
    full |-> count == CNT_W'(DEPTH));

  // R8
  issue_frees_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && issueValid) |-> dispEn);

  // R5
  head_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count != '0 && rdyVec[0]) |-> (issueValid && issueIdx == '0));

  // R2
  issue_from_occupied_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> CNT_W'(issueIdx) < count);

  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R6
  single_leave_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueEn && !dispEn) |=> count == $past(count) - CNT_W'(1));

endmodule

bind tag_match_station rs_checker #(.DEPTH(DEPTH)) u_rs_checker (
  .clk        (clk),
  .rstN       (rstN),
  .dispValid  (dispValid),
  .full       (full),
  .issueValid (issueValid),
  .dispEn     (strobe.dispEn),
  .issueEn    (strobe.issueEn),
  .count      (count),
  .rdyVec     (rdyVec),
  .issueIdx   (issueIdx)
);

// File: tb/tag_match_station_bench.sv
module tag_match_station_bench;

  localparam int DEPTH  = 4;
  localparam int OP_W   = 3;
  localparam int TAG_W  = 4;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              dispValid = 1'b0;
  logic [OP_W-1:0]   dispOp = '0;
  logic              dispARdy = 1'b0;
  logic [TAG_W-1:0]  dispATag = '0;
  logic [DATA_W-1:0] dispAVal = '0;
  logic              dispBRdy = 1'b0;
  logic [TAG_W-1:0]  dispBTag = '0;
  logic [DATA_W-1:0] dispBVal = '0;
  logic              bcValid = 1'b0;
  logic [TAG_W-1:0]  bcTag = '0;
  logic [DATA_W-1:0] bcVal = '0;
  logic              full;
  logic              issueValid;
  logic [OP_W-1:0]   issueOp;
  logic [DATA_W-1:0] issueA;
  logic [DATA_W-1:0] issueB;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tag_match_station #(
    .DEPTH(DEPTH), .OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_tag_match_station (
    .clk(clk), .rstN(rstN),
    .dispValid(dispValid), .dispOp(dispOp),
    .dispARdy(dispARdy), .dispATag(dispATag), .dispAVal(dispAVal),
    .dispBRdy(dispBRdy), .dispBTag(dispBTag), .dispBVal(dispBVal),
    .bcValid(bcValid), .bcTag(bcTag), .bcVal(bcVal),
    .full(full), .issueValid(issueValid), .issueOp(issueOp),
    .issueA(issueA), .issueB(issueB)
  );

  // Expected fields describe the outputs seen before this row's inputs reach an edge
  typedef struct packed {
    logic              dv;
    logic [OP_W-1:0]   op;
    logic              ar;
    logic [TAG_W-1:0]  at;
    logic [DATA_W-1:0] av;
    logic              br;
    logic [TAG_W-1:0]  bt;
    logic [DATA_W-1:0] bv;
    logic              bcv;
    logic [TAG_W-1:0]  bct;
    logic [DATA_W-1:0] bcd;
    logic              eIv;
    logic [OP_W-1:0]   eOp;
    logic [DATA_W-1:0] eA;
    logic [DATA_W-1:0] eB;
    logic              eFull;
    logic [3:0]        req;
  } vec_t;

  localparam int NVEC = 23;
  localparam vec_t VECS [NVEC] = '{
    '{1,1,1,0,10,1,0,20, 0,0,0,  0,0,0,0,0,   1},  // R1 empty; dispatch ready op1
    '{1,2,1,0,3,0,5,0,   0,0,0,  1,1,10,20,0, 2},  // R2 op1 issues
    '{0,0,0,0,0,0,0,0,   1,6,99, 0,0,0,0,0,   3},  // R3 op2 waits on tag 5
    '{0,0,0,0,0,0,0,0,   1,5,55, 0,0,0,0,0,   3},  // R3 tag 6 ignored
    '{1,3,0,7,0,1,0,4,   1,7,77, 1,2,3,55,0,  3},  // R3 op2 filled; R4 same-cycle
    '{1,4,0,1,0,1,0,1,   0,0,0,  1,3,77,4,0,  4},  // R4 op3 ready at once
    '{1,5,1,0,5,1,0,5,   0,0,0,  0,0,0,0,0,   5},  // R5 op4 waits
    '{1,6,1,0,6,0,2,0,   0,0,0,  1,5,5,5,0,   5},  // R5 younger ready op5 goes
    '{1,7,1,0,7,1,0,7,   1,2,22, 0,0,0,0,0,   5},  // R5 op6 waits on 2
    '{0,0,0,0,0,0,0,0,   1,1,11, 1,6,6,22,0,  5},  // R5 op6 older than op7
    '{0,0,0,0,0,0,0,0,   0,0,0,  1,4,11,1,0,  6},  // R6 op4 before op7
    '{1,1,0,3,0,0,3,0,   0,0,0,  1,7,7,7,0,   6},  // R6 op7 last
    '{1,2,0,4,0,1,0,2,   0,0,0,  0,0,0,0,0,   3},  // R3 fill queue
    '{1,3,0,4,0,1,4,3,   0,0,0,  0,0,0,0,0,   9},  // R9 B ready with tag 4
    '{1,4,0,4,0,1,0,4,   0,0,0,  0,0,0,0,0,   7},  // R7 three held, not full
    '{1,5,1,0,9,1,0,9,   0,0,0,  0,0,0,0,1,   7},  // R7 full; op5 dropped
    '{0,0,0,0,0,0,0,0,   1,3,33, 0,0,0,0,1,   7},  // R7 still full
    '{1,6,1,0,1,1,0,2,   0,0,0,  1,1,33,33,0, 8},  // R8 issue frees slot
    '{0,0,0,0,0,0,0,0,   1,4,44, 1,6,1,2,0,   8},  // R8 op6 was accepted
    '{0,0,0,0,0,0,0,0,   0,0,0,  1,2,44,2,0,  10}, // R10 one per cycle
    '{0,0,0,0,0,0,0,0,   0,0,0,  1,3,44,3,0,  9},  // R9 B kept at 3
    '{0,0,0,0,0,0,0,0,   0,0,0,  1,4,44,4,0,  10}, // R10 last one
    '{0,0,0,0,0,0,0,0,   0,0,0,  0,0,0,0,0,   7}   // R7 dropped op5 never seen
  };

  task automatic check_out(input logic eIv, input logic [OP_W-1:0] eOp,
                           input logic [DATA_W-1:0] eA, input logic [DATA_W-1:0] eB,
                           input logic eFull, input int req);
    checks++;
    if (issueValid !== eIv || full !== eFull ||
        (eIv && (issueOp !== eOp || issueA !== eA || issueB !== eB))) begin
      failures++;
      $display("FAIL R%0d: got iv=%0b op=%0d a=%0d b=%0d full=%0b exp iv=%0b op=%0d a=%0d b=%0d full=%0b",
               req, issueValid, issueOp, issueA, issueB, full, eIv, eOp, eA, eB, eFull);
    end
  endtask

  task automatic drive(input vec_t v);
    dispValid = v.dv; dispOp = v.op;
    dispARdy = v.ar; dispATag = v.at; dispAVal = v.av;
    dispBRdy = v.br; dispBTag = v.bt; dispBVal = v.bv;
    bcValid = v.bcv; bcTag = v.bct; bcVal = v.bcd;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    check_out(1'b0, '0, '0, '0, 1'b0, 1);
    rstN = 1'b1;
    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      check_out(VECS[k].eIv, VECS[k].eOp, VECS[k].eA, VECS[k].eB,
                VECS[k].eFull, int'(VECS[k].req));
      drive(VECS[k]);
    end

    // R1 directed: reset clears held entries
    @(negedge clk);
    drive('{1,2,0,9,0,1,0,1, 0,0,0, 0,0,0,0,0,1});
    @(negedge clk);
    drive('{1,3,1,0,8,1,0,8, 0,0,0, 0,0,0,0,0,1});
    @(negedge clk);
    drive('0);
    rstN = 1'b0;
    @(negedge clk);
    check_out(1'b0, '0, '0, '0, 1'b0, 1);
    rstN = 1'b1;
    bcValid = 1'b1; bcTag = 4'd9; bcVal = 8'd90;
    @(negedge clk);
    bcValid = 1'b0;
    @(negedge clk);
    // R1 nothing held from before the reset
    check_out(1'b0, '0, '0, '0, 1'b0, 1);

    // R2 directed: ready dispatch issues in the next cycle
    drive('{1,5,1,0,8'hA5,1,0,8'h5A, 0,0,0, 0,0,0,0,0,2});
    @(negedge clk);
    drive('0);
    check_out(1'b1, 3'd5, 8'hA5, 8'h5A, 1'b0, 2);
    @(negedge clk);
    check_out(1'b0, '0, '0, '0, 1'b0, 2);

    // R4 directed: both operands share the broadcast tag at dispatch
    drive('{1,6,0,3,0,0,3,0, 1,3,8'h3C, 0,0,0,0,0,4});
    @(negedge clk);
    drive('0);
    check_out(1'b1, 3'd6, 8'h3C, 8'h3C, 1'b0, 4);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin : wait_done
        wait (done);
      end
      begin : watchdog
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: got no completion, exp completion within 5000 cycles");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule